// File: doc/BRIEF.md
# Ping-Pong Burst Write Address Manager

This block moves data from a staging FIFO into memory as fixed-length burst writes. It fills two halves of a software-owned buffer in alternation. Software supplies a base address, a total buffer size and a high-water mark, then pulses start. The block watches the FIFO fill level. Whenever at least one full burst of words is waiting, it requests a burst at the current write address. After the memory side acknowledges the request, the block strobes the FIFO read line once per word, and the memory side takes those words straight from the FIFO output.

A byte count is kept for the active half. When a completed burst pushes that count past the high-water mark, or fills the half completely, the block raises that half's full flag for software. It then moves to the other half, provided software has released it. If both halves are still marked full, the block stalls and counts the stalled cycles in a 32-bit counter until a release pulse frees a half. A stop request is honoured only at a burst boundary.

Top module: `pp_burst_dma`

## Requirements
- R1: While reset is held and after it, `mem_req`, `src_rd`, `busy` and `region_full` are 0, and `wait_count` is 0.
- R2: A burst is requested only while `busy` is 1 and `src_level` is at least 16. `mem_req` stays at 1 with an unchanged `mem_addr` until `mem_ack` is seen.
- R3: After an acknowledged request, `src_rd` is 1 for exactly 16 consecutive cycles, one per 128-bit word. Each later burst in the same half has an address 256 higher than the one before.
- R4: The first burst after start goes to `cfg_base` with `active_region` = 0. Half 1 begins at `cfg_base + cfg_size/2`.
- R5: When a burst completes and the half's byte count becomes greater than `cfg_hwm`, or reaches `cfg_size/2`, `region_full[h]` for the active half h is set to 1.
- R6: After a half is marked full, the block moves to the other half only if that half's flag is 0. It then restarts the byte count at zero, points the address at that half's base, and shows the new half on `active_region` (0 = lower half, 1 = upper half).
- R7: While both halves are full, no burst is requested, and `wait_count` rises by exactly one per stalled cycle.
- R8: A one-cycle pulse on `sw_release[h]` clears `region_full[h]` in the next cycle, unless the same half is being marked full in that cycle.
- R9: A stop pulse ends operation only at a burst boundary. A burst in progress still delivers all 16 reads, after which `busy` falls and no further request appears. A stop during a stall takes effect at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_base | input | 32 | Buffer start byte address, captured at start |
| cfg_size | input | 32 | Total buffer size in bytes, captured at start |
| cfg_hwm | input | 32 | Per-half high-water mark in bytes, captured at start |
| ctl_start | input | 1 | Start pulse, accepted while idle |
| ctl_stop | input | 1 | Stop pulse |
| sw_release | input | 2 | Per-half release pulses from software |
| src_level | input | 10 | Words held in the staging FIFO |
| src_rd | output | 1 | FIFO read strobe, one per transferred word |
| mem_req | output | 1 | Burst request |
| mem_addr | output | 32 | Burst start byte address |
| mem_ack | input | 1 | Burst request accepted |
| region_full | output | 2 | Per-half full flags |
| active_region | output | 1 | Half currently being written |
| busy | output | 1 | Block is running |
| wait_count | output | 32 | Cycles spent stalled with both halves full |

## Verification
The assertions rely on a few properties of the inputs. The FIFO is expected to hold at least 16 words whenever a burst is acknowledged, so that 16 back-to-back reads are always possible. `mem_ack` is expected only while `mem_req` is high. The buffer size is expected to be a multiple of 512 bytes, so each half ends on a burst boundary. The stimulus respects all of these: the FIFO level is held constant at 16 or above during bursts, the memory model answers only a pending request (optionally after a hold-off), and every configuration uses a size that is a multiple of 512.

// File: rtl/pp_dma_pkg.sv
package pp_dma_pkg;

    localparam int unsigned ADDR_W = 32;

    typedef logic [ADDR_W-1:0] addr_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RUN,
        ST_REQ,
        ST_DATA,
        ST_SWITCH
    } dma_state_e;

    typedef struct packed {
        addr_t base;
        addr_t half;
        addr_t hwm;
    } dma_cfg_t;

    // Start address of half r of the buffer
    function automatic addr_t region_base(input dma_cfg_t c, input logic r);
        return r ? (c.base + c.half) : c.base;
    endfunction

    // Half is finished when the filled bytes pass the mark or reach the half size
    function automatic logic region_done(input addr_t filled, input dma_cfg_t c);
        return (filled > c.hwm) || (filled >= c.half);
    endfunction

endpackage

// File: rtl/pp_beat_counter.sv
module pp_beat_counter #(
    parameter int unsigned BEATS = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic active,
    output logic last
);
    localparam int unsigned BW = (BEATS > 1) ? $clog2(BEATS) : 1;
    localparam logic [BW-1:0] LAST_IDX = BW'(BEATS - 1);

    logic [BW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || !active) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign last = active && (cnt_q == LAST_IDX);

    // R3: the data phase may not end before the final beat
    a_r3_beats_contiguous: assert property (@(posedge clk) disable iff (rst)
        (active && !last) |=> active);

endmodule

// File: rtl/pp_region_flags.sv
module pp_region_flags (
    input  logic       clk,
    input  logic       rst,
    input  logic       set_en,
    input  logic       set_idx,
    input  logic [1:0] rel_i,
    output logic [1:0] full
);
    logic [1:0] full_q;

    for (genvar g = 0; g < 2; g++) begin : g_half
        always_ff @(posedge clk) begin
            if (rst) begin
                full_q[g] <= 1'b0;
            end else if (set_en && (set_idx == 1'(g))) begin
                full_q[g] <= 1'b1;
            end else if (rel_i[g]) begin
                full_q[g] <= 1'b0;
            end
        end

        // R8: a release pulse frees the half one cycle later
        a_r8_release_clears: assert property (@(posedge clk) disable iff (rst)
            (rel_i[g] && !(set_en && (set_idx == 1'(g)))) |=> !full[g]);

        // R5: marking a half full is visible in the next cycle
        a_r5_set_visible: assert property (@(posedge clk) disable iff (rst)
            (set_en && (set_idx == 1'(g))) |=> full[g]);
    end

    assign full = full_q;

endmodule

// File: rtl/pp_wait_counter.sv
module pp_wait_counter #(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         inc,
    output logic [W-1:0] count
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (inc) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign count = cnt_q;

    // R7: one step per stalled cycle, no drift otherwise
    a_r7_wait_step: assert property (@(posedge clk) disable iff (rst)
        inc |=> (count == $past(count) + W'(1)));

    a_r7_wait_hold: assert property (@(posedge clk) disable iff (rst)
        !inc |=> $stable(count));

endmodule

// File: rtl/pp_burst_dma.sv
module pp_burst_dma
    import pp_dma_pkg::*;
#(
    parameter int unsigned BURST_WORDS = 16,
    parameter int unsigned WORD_BYTES  = 16,
    parameter int unsigned LEVEL_W     = 10,
    parameter int unsigned WAIT_W      = 32
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [ADDR_W-1:0]  cfg_base,
    input  logic [ADDR_W-1:0]  cfg_size,
    input  logic [ADDR_W-1:0]  cfg_hwm,
    input  logic               ctl_start,
    input  logic               ctl_stop,
    input  logic [1:0]         sw_release,
    input  logic [LEVEL_W-1:0] src_level,
    output logic               src_rd,
    output logic               mem_req,
    output logic [ADDR_W-1:0]  mem_addr,
    input  logic               mem_ack,
    output logic [1:0]         region_full,
    output logic               active_region,
    output logic               busy,
    output logic [WAIT_W-1:0]  wait_count
);
    localparam int unsigned BURST_BYTES = BURST_WORDS * WORD_BYTES;
    localparam addr_t       STEP        = addr_t'(BURST_BYTES);
    localparam logic [LEVEL_W-1:0] MIN_LEVEL = LEVEL_W'(BURST_WORDS);

    dma_state_e state_q, state_d;
    dma_cfg_t   cfg_q, cfg_d;
    logic       cur_q, cur_d;
    addr_t      addr_q, addr_d;
    addr_t      fill_q, fill_d;
    logic       stop_q;

    logic       beat_last;
    logic       set_en;
    logic       wait_inc;
    logic       level_ok;
    logic       stop_now;
    addr_t      fill_next;

    assign level_ok  = (src_level >= MIN_LEVEL);
    assign stop_now  = stop_q || ctl_stop;
    assign fill_next = fill_q + STEP;

    pp_beat_counter #(.BEATS(BURST_WORDS)) u_beats (
        .clk    (clk),
        .rst    (rst),
        .active (state_q == ST_DATA),
        .last   (beat_last)
    );

    pp_region_flags u_flags (
        .clk     (clk),
        .rst     (rst),
        .set_en  (set_en),
        .set_idx (cur_q),
        .rel_i   (sw_release),
        .full    (region_full)
    );

    pp_wait_counter #(.W(WAIT_W)) u_wait (
        .clk   (clk),
        .rst   (rst),
        .inc   (wait_inc),
        .count (wait_count)
    );

    always_comb begin
        state_d  = state_q;
        cfg_d    = cfg_q;
        cur_d    = cur_q;
        addr_d   = addr_q;
        fill_d   = fill_q;
        set_en   = 1'b0;
        wait_inc = 1'b0;
        case (state_q)
            ST_IDLE: begin
                if (ctl_start) begin
                    cfg_d.base = cfg_base;
                    cfg_d.half = cfg_size >> 1;
                    cfg_d.hwm  = cfg_hwm;
                    cur_d      = 1'b0;
                    addr_d     = cfg_base;
                    fill_d     = '0;
                    state_d    = ST_RUN;
                end
            end
            ST_RUN: begin
                if (stop_now) begin
                    state_d = ST_IDLE;
                end else if (level_ok) begin
                    state_d = ST_REQ;
                end
            end
            ST_REQ: begin
                if (mem_ack) begin
                    state_d = ST_DATA;
                end
            end
            ST_DATA: begin
                if (beat_last) begin
                    addr_d = addr_q + STEP;
                    fill_d = fill_next;
                    if (region_done(fill_next, cfg_q)) begin
                        set_en  = 1'b1;
                        state_d = ST_SWITCH;
                    end else begin
                        state_d = ST_RUN;
                    end
                end
            end
            ST_SWITCH: begin
                if (stop_now) begin
                    state_d = ST_IDLE;
                end else if (!region_full[!cur_q]) begin
                    cur_d   = !cur_q;
                    addr_d  = region_base(cfg_q, !cur_q);
                    fill_d  = '0;
                    state_d = ST_RUN;
                end else begin
                    wait_inc = 1'b1;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cfg_q   <= '0;
            cur_q   <= 1'b0;
            addr_q  <= '0;
            fill_q  <= '0;
            stop_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            cfg_q   <= cfg_d;
            cur_q   <= cur_d;
            addr_q  <= addr_d;
            fill_q  <= fill_d;
            stop_q  <= (state_d != ST_IDLE) && (stop_q || ctl_stop);
        end
    end

    assign mem_req       = (state_q == ST_REQ);
    assign mem_addr      = addr_q;
    assign src_rd        = (state_q == ST_DATA);
    assign busy          = (state_q != ST_IDLE);
    assign active_region = cur_q;

    // R2: a new request only follows a FIFO holding a full burst
    a_r2_req_needs_level: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_req) |-> ($past(src_level) >= MIN_LEVEL));

    // R2: request and address hold until acknowledged
    a_r2_req_hold: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

    // R3: reading starts right after the acknowledge
    a_r3_rd_after_ack: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_ack) |=> src_rd);

    // R4: every requested burst lies inside the active half
    a_r4_in_region: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> ((mem_addr >= region_base(cfg_q, cur_q)) &&
                     ((mem_addr - region_base(cfg_q, cur_q)) < cfg_q.half)));

    // R6: a switch only lands on a half that was free
    a_r6_switch_free0: assert property (@(posedge clk) disable iff (rst)
        (($past(state_q) == ST_SWITCH) && (state_q == ST_RUN) && !active_region)
            |-> !$past(region_full[0]));

    a_r6_switch_free1: assert property (@(posedge clk) disable iff (rst)
        (($past(state_q) == ST_SWITCH) && (state_q == ST_RUN) && active_region)
            |-> !$past(region_full[1]));

    // R9: the block never leaves mid-burst
    a_r9_stop_at_boundary: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> (($past(state_q) != ST_DATA) && ($past(state_q) != ST_REQ)));

endmodule

// File: tb/pp_burst_dma_test.sv
`timescale 1ns/1ps
module pp_burst_dma_test;

    logic        clk = 1'b0;
    logic        rst;
    logic [31:0] cfg_base, cfg_size, cfg_hwm;
    logic        ctl_start, ctl_stop;
    logic [1:0]  sw_release;
    logic [9:0]  src_level;
    logic        src_rd, mem_req, mem_ack;
    logic [31:0] mem_addr;
    logic [1:0]  region_full;
    logic        active_region, busy;
    logic [31:0] wait_count;

    int n_checks = 0;
    int n_errors = 0;
    int n_req = 0;
    int n_rd = 0;
    logic hold_ack = 1'b0;
    logic [31:0] addr_log [0:63];

    always #4 clk = ~clk;

    pp_burst_dma uut (
        .clk(clk), .rst(rst), .cfg_base(cfg_base), .cfg_size(cfg_size),
        .cfg_hwm(cfg_hwm), .ctl_start(ctl_start), .ctl_stop(ctl_stop),
        .sw_release(sw_release), .src_level(src_level), .src_rd(src_rd),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack),
        .region_full(region_full), .active_region(active_region),
        .busy(busy), .wait_count(wait_count)
    );

    // base, size, high-water mark, expected bursts until half 0 is full
    localparam logic [31:0] VEC [0:3][0:3] = '{
        '{32'h1000_0000, 32'h0000_2000, 32'h0000_0800, 32'd9},
        '{32'h0002_0000, 32'h0000_1000, 32'h0000_0FFF, 32'd8},
        '{32'h0000_4000, 32'h0000_0400, 32'h0000_0000, 32'd1},
        '{32'h8000_0000, 32'h0000_4000, 32'h0000_0100, 32'd2}
    };

    // memory responder: acknowledges a pending request at the falling edge
    initial begin
        mem_ack = 1'b0;
        forever begin
            @(negedge clk);
            if (src_rd) n_rd++;
            if (mem_req && !mem_ack && !hold_ack) begin
                if (n_req < 64) addr_log[n_req] = mem_addr;
                n_req++;
                mem_ack = 1'b1;
            end else begin
                mem_ack = 1'b0;
            end
        end
    end

    task automatic tick(input int n);
        repeat (n) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic check(input bit ok, input string req, input logic [63:0] act,
                         input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        ctl_start = 1'b0;
        ctl_stop = 1'b0;
        sw_release = 2'b00;
        src_level = 10'd64;
        hold_ack = 1'b0;
        tick(3);
        rst = 1'b0;
        n_req = 0;
        n_rd = 0;
        tick(1);
    endtask

    task automatic pulse_start();
        ctl_start = 1'b1;
        tick(1);
        ctl_start = 1'b0;
    endtask

    task automatic pulse_stop();
        ctl_stop = 1'b1;
        tick(1);
        ctl_stop = 1'b0;
    endtask

    task automatic wait_reqs(input int target);
        for (int i = 0; i < 3000 && n_req < target; i++) tick(1);
    endtask

    task automatic wait_full0();
        for (int i = 0; i < 3000 && !region_full[0]; i++) tick(1);
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 3000 && busy; i++) tick(1);
    endtask

    initial begin
        #(8 * 150000);
        n_errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        cfg_base = 32'h0; cfg_size = 32'h0; cfg_hwm = 32'h0;
        do_reset();

        // R1: state after reset
        check(!mem_req && !src_rd && !busy && region_full == 2'b00, "R1 outputs",
              {mem_req, src_rd, busy, region_full}, 0);
        check(wait_count == 32'd0, "R1 wait_count", wait_count, 0);

        // R2: FIFO level gating and request hold
        cfg_base = 32'h0000_A000; cfg_size = 32'h0000_2000; cfg_hwm = 32'h0000_1000;
        src_level = 10'd15;
        pulse_start();
        tick(40);
        check(n_req == 0 && !mem_req, "R2 no request below 16 words", n_req, 0);
        check(busy, "R2 running while starved", busy, 1);
        hold_ack = 1'b1;
        src_level = 10'd16;
        tick(8);
        check(mem_req && mem_addr == 32'h0000_A000, "R2 request held", mem_addr, 32'h0000_A000);
        hold_ack = 1'b0;
        wait_reqs(1);
        check(n_req == 1 && addr_log[0] == 32'h0000_A000, "R4 first burst at base",
              addr_log[0], 32'h0000_A000);
        pulse_stop();
        wait_idle();
        check(n_rd == 16, "R3 sixteen reads per burst", n_rd, 16);

        // table of configurations: R3 R4 R5 R6
        for (int v = 0; v < 4; v++) begin
            logic [31:0] base, size, hwm;
            int nb;
            bit addr_ok;
            base = VEC[v][0]; size = VEC[v][1]; hwm = VEC[v][2]; nb = int'(VEC[v][3]);
            do_reset();
            cfg_base = base; cfg_size = size; cfg_hwm = hwm;
            pulse_start();
            wait_full0();
            check(n_req == nb, "R5 bursts until half full", n_req, nb);
            addr_ok = 1'b1;
            for (int k = 0; k < nb; k++)
                if (addr_log[k] != base + 32'(k) * 32'd256) addr_ok = 1'b0;
            check(addr_ok, "R3 address step of 256", addr_log[nb - 1],
                  base + 32'(nb - 1) * 32'd256);
            wait_reqs(nb + 1);
            check(addr_log[nb] == base + (size >> 1), "R4 second half base",
                  addr_log[nb], base + (size >> 1));
            check(active_region == 1'b1, "R6 active half switched", active_region, 1);
            pulse_stop();
            wait_idle();
            check(!busy && n_rd == 16 * n_req, "R9 stop after full burst", n_rd, 16 * n_req);
        end

        // R7 R8: both halves full, stall, then release
        begin
            logic [31:0] wc0;
            do_reset();
            cfg_base = 32'h0000_3000; cfg_size = 32'h0000_0400; cfg_hwm = 32'h0;
            pulse_start();
            wait_reqs(2);
            for (int i = 0; i < 200 && region_full != 2'b11; i++) tick(1);
            tick(3);
            wc0 = wait_count;
            tick(10);
            check(wait_count - wc0 == 32'd10, "R7 wait counter per cycle",
                  wait_count - wc0, 10);
            check(n_req == 2 && !mem_req, "R7 no burst while stalled", n_req, 2);
            sw_release = 2'b01;
            tick(1);
            sw_release = 2'b00;
            check(region_full == 2'b10, "R8 release clears flag", region_full, 2'b10);
            wait_reqs(3);
            check(addr_log[2] == 32'h0000_3000, "R6 resume in released half",
                  addr_log[2], 32'h0000_3000);
            for (int i = 0; i < 200 && region_full != 2'b11; i++) tick(1);
            check(region_full == 2'b11, "R5 half refilled", region_full, 2'b11);
            pulse_stop();
            tick(2);
            check(!busy && n_rd == 48, "R9 stop during stall", n_rd, 48);
        end

        // R9: stop in the middle of a burst
        do_reset();
        cfg_base = 32'h0004_0000; cfg_size = 32'h0001_0000; cfg_hwm = 32'h0000_8000;
        pulse_start();
        for (int i = 0; i < 200 && !src_rd; i++) tick(1);
        tick(3);
        pulse_stop();
        check(src_rd, "R9 burst continues after stop", src_rd, 1);
        wait_idle();
        tick(20);
        check(n_req == 1 && n_rd == 16, "R9 burst completed then idle", n_rd, 16);
        check(!busy && !mem_req, "R9 no further request", {busy, mem_req}, 0);

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule